// File: doc/BRIEF.md
# Data-Dependent Fail-First Vector Sequencer

This block steps through the elements of a vector condition-register operation, one element per clock. For each element it presents an index to an external comparison datapath, takes back that element's 4-bit comparison result and its predicate bit, and decides three things. It decides whether the element is written, which destination index receives the write, and whether the loop ends at that element. In fail-first operation the loop stops as soon as a selected condition bit fails, and the vector length (VL) is rewritten from the number of elements already handled.

A single start pulse latches the operating options and the incoming VL. The mode field chooses one of four behaviours. Plain per-element, scalar-reduce and fail-first are the three kinds. Fail-first comes in two variants: one keeps the failing element, the other drops it. Options select the tested bit, inversion of the test, top-down walking, the treatment of masked-off elements, a narrow or wide destination, and a scalar destination. Reserved option combinations are reported through an illegal flag, and no element is processed when one is seen. When the loop ends, done rises and the truncated or unchanged VL is held until the next start.

Top module: `ffvec_seq`

## Requirements
- R1: `mode_kind` decodes as 2'b00 plain, 2'b10 scalar-reduce, 2'b01 fail-first dropping the failing element, and 2'b11 fail-first keeping it. Any non-zero value enables map-reduce, and bit 0 alone enables fail-first.
- R2: When `mode_kind[0]` is 0 and either `opt_snz` or `opt_inv` is 1, `illegal` is 1 and `done` is 1 one cycle after start. No write occurs, and `vl_out` equals `vl_in`.
- R3: In forward order the elements are taken in the order 0, 1, 2 and so on. The tested bit of an active, unmasked element is `elem_res[bit_sel]`. When it is 1 in fail-first mode and the failing element is the k-th processed (counting from 0), the loop stops and `vl_out` becomes k.
- R4: With `mode_kind`=2'b11, the failing element is written and `vl_out` becomes k+1. With 2'b01, the failing element is not written.
- R5: If no element fails, every active element is written, `vl_out` keeps the value of `vl_in`, and `done` rises together with the last write. This also holds at the largest VL.
- R6: With `dst_scalar`=1, every write goes to index 0. A map-reduce run visits every element, while a plain run stops after its first active element.
- R7: An element with predicate 0 is active (zeroed and written) when zeroing is on. Zeroing is forced on in fail-first mode with `opt_wide`=0; otherwise it follows `opt_zero`. With zeroing off, such an element is skipped with no write and no test.
- R8: A zeroed masked-off element has the test value `opt_snz`. With SNZ set it fails and stops a fail-first loop.
- R9: With `opt_inv`=1, an unmasked element fails when `elem_res[bit_sel]` is 0.
- R10: With `opt_rev`=1, the elements are taken in the order VL-1 down to 0, and the truncated VL counts the elements processed from the top.
- R11: A start with `vl_in`=0 gives `done`=1 one cycle later, with no write and `vl_out`=0.
- R12: After reset, `done`, `illegal`, `wr_en`, `elem_req` and `vl_out` are all 0. After `done`, both `done` and `vl_out` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latches options and VL, begins a run |
| mode_kind | input | 2 | Mode field, see R1 |
| opt_snz | input | 1 | Masked-off zeroed elements test as true |
| opt_inv | input | 1 | Invert the tested bit |
| opt_rev | input | 1 | Walk from the top element downwards |
| opt_wide | input | 1 | 1: wide destination, zeroing from opt_zero; 0: narrow destination |
| opt_zero | input | 1 | Zeroing request for the wide variant and non-fail-first modes |
| bit_sel | input | 2 | Selects the tested result bit, 0 to 3 |
| dst_scalar | input | 1 | Destination is a scalar (index 0) |
| vl_in | input | VLW | Vector length at start |
| elem_req | output | 1 | An element index is being issued this cycle |
| elem_idx | output | IDXW | Index of the element being issued |
| elem_res | input | 4 | Comparison result for elem_idx |
| elem_pred | input | 1 | Predicate bit for elem_idx |
| wr_en | output | 1 | Write strobe for the element processed in the previous cycle |
| wr_idx | output | IDXW | Destination index of that write |
| vl_out | output | VLW | Resulting vector length |
| done | output | 1 | Run finished; held until next start |
| illegal | output | 1 | Reserved encoding detected at start |

## Verification
The embedded properties assume that `elem_res` and `elem_pred` are stable and valid for the whole cycle in which `elem_req` is high. They also assume that option inputs are only meaningful on the start cycle, and that `vl_in` never exceeds the parameterised maximum. The stimulus follows these rules: a memory indexed by `elem_idx` supplies the per-element inputs, options change only at the falling edge before the start pulse, and every VL lies between 0 and the maximum. A scoreboard queue holds the expected write indices in issue order. Each write strobe is popped and compared against it, and the final VL and illegal flag are compared once the strobe has cleared.

// File: rtl/ffvec_pkg.sv
package ffvec_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'b00,
    KIND_FF     = 2'b01,
    KIND_REDUCE = 2'b10,
    KIND_FF_VLI = 2'b11
  } run_kind_e;

  typedef struct packed {
    logic       ff_en;
    logic       mapred;
    logic       vli;
    logic       zero;
    logic       snz;
    logic       inv;
    logic       rev;
    logic [1:0] bsel;
    logic       scalar_dst;
  } run_cfg_t;

endpackage

// File: rtl/ffvec_decode.sv
module ffvec_decode
  import ffvec_pkg::*;
(
  input  logic [1:0] mode_kind,
  input  logic       opt_snz,
  input  logic       opt_inv,
  input  logic       opt_rev,
  input  logic       opt_wide,
  input  logic       opt_zero,
  input  logic [1:0] bit_sel,
  input  logic       dst_scalar,
  output run_cfg_t   cfg,
  output logic       bad_enc
);

  run_kind_e kind;

  always_comb begin
    kind           = run_kind_e'(mode_kind);
    cfg.ff_en      = (kind == KIND_FF) || (kind == KIND_FF_VLI);
    cfg.mapred     = (kind != KIND_PLAIN);
    cfg.vli        = (kind == KIND_FF_VLI);
    // narrow fail-first forces zeroing on both sides
    cfg.zero       = (cfg.ff_en && !opt_wide) ? 1'b1 : opt_zero;
    cfg.snz        = opt_snz;
    cfg.inv        = opt_inv;
    cfg.rev        = opt_rev;
    cfg.bsel       = bit_sel;
    cfg.scalar_dst = dst_scalar;
    bad_enc        = !cfg.ff_en && (opt_snz || opt_inv);
  end

endmodule

// File: rtl/ffvec_eval.sv
module ffvec_eval
  import ffvec_pkg::*;
(
  input  run_cfg_t   cfg,
  input  logic       pred,
  input  logic [3:0] res,
  output logic       skip,
  output logic       fail,
  output logic       wr
);

  logic active;
  logic tbit;

  always_comb begin
    active = pred || cfg.zero;
    skip   = !active;
    tbit   = pred ? (res[cfg.bsel] ^ cfg.inv) : cfg.snz;
    fail   = cfg.ff_en && active && tbit;
    wr     = active && (!fail || cfg.vli);
  end

endmodule

// File: rtl/ffvec_walker.sv
module ffvec_walker #(
  parameter int IDXW = 6,
  parameter int VLW  = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            rev,
  input  logic [VLW-1:0]  vl,
  output logic [IDXW-1:0] idx,
  output logic [VLW-1:0]  cnt,
  output logic            last
);

  logic [VLW-1:0] vl_q;
  logic           rev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      cnt   <= '0;
      vl_q  <= '0;
      rev_q <= 1'b0;
    end else if (load) begin
      idx   <= rev ? IDXW'(vl - VLW'(1)) : '0;
      cnt   <= '0;
      vl_q  <= vl;
      rev_q <= rev;
    end else if (step) begin
      idx <= rev_q ? idx - IDXW'(1) : idx + IDXW'(1);
      cnt <= cnt + VLW'(1);
    end
  end

  assign last = (cnt == vl_q - VLW'(1));

  a_r3_forward_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !rev_q) |=> (idx == $past(idx) + IDXW'(1)));

  a_r10_reverse_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load && rev_q) |=> (idx == $past(idx) - IDXW'(1)));

endmodule

// File: rtl/ffvec_seq.sv
module ffvec_seq
  import ffvec_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int IDXW = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode_kind,
  input  logic            opt_snz,
  input  logic            opt_inv,
  input  logic            opt_rev,
  input  logic            opt_wide,
  input  logic            opt_zero,
  input  logic [1:0]      bit_sel,
  input  logic            dst_scalar,
  input  logic [VLW-1:0]  vl_in,
  output logic            elem_req,
  output logic [IDXW-1:0] elem_idx,
  input  logic [3:0]      elem_res,
  input  logic            elem_pred,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [VLW-1:0]  vl_out,
  output logic            done,
  output logic            illegal
);

  run_cfg_t       cfg_d, cfg_q;
  logic           bad_d;
  logic           busy_q;
  logic [VLW-1:0] vl_cap_q;
  logic           e_skip, e_fail, e_wr;
  logic [VLW-1:0] cnt;
  logic           last;
  logic           step;

  ffvec_decode u_dec (
    .mode_kind (mode_kind),
    .opt_snz   (opt_snz),
    .opt_inv   (opt_inv),
    .opt_rev   (opt_rev),
    .opt_wide  (opt_wide),
    .opt_zero  (opt_zero),
    .bit_sel   (bit_sel),
    .dst_scalar(dst_scalar),
    .cfg       (cfg_d),
    .bad_enc   (bad_d)
  );

  ffvec_eval u_eval (
    .cfg (cfg_q),
    .pred(elem_pred),
    .res (elem_res),
    .skip(e_skip),
    .fail(e_fail),
    .wr  (e_wr)
  );

  assign step = busy_q && !start;

  ffvec_walker #(.IDXW(IDXW), .VLW(VLW)) u_walk (
    .clk (clk),
    .rst (rst),
    .load(start),
    .step(step),
    .rev (opt_rev),
    .vl  (vl_in),
    .idx (elem_idx),
    .cnt (cnt),
    .last(last)
  );

  assign elem_req = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      busy_q   <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      vl_out   <= '0;
      vl_cap_q <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start) begin
        cfg_q    <= cfg_d;
        illegal  <= bad_d;
        vl_out   <= vl_in;
        vl_cap_q <= vl_in;
        done     <= bad_d || (vl_in == '0);
        busy_q   <= !bad_d && (vl_in != '0);
      end else if (busy_q) begin
        wr_en  <= e_wr;
        wr_idx <= cfg_q.scalar_dst ? '0 : elem_idx;
        if (e_fail) begin
          vl_out <= cnt + VLW'(cfg_q.vli);
          done   <= 1'b1;
          busy_q <= 1'b0;
        end else if (last || (!e_skip && !cfg_q.mapred && cfg_q.scalar_dst)) begin
          done   <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  a_r2_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_en);

  a_r4_write_follows_issue: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy_q));

  a_r5_vl_never_grows: assert property (@(posedge clk) disable iff (rst)
    done |-> (vl_out <= vl_cap_q));

  a_r12_result_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(vl_out)));

  a_r11_empty_vector: assert property (@(posedge clk) disable iff (rst)
    (start && vl_in == '0) |=> (done && !elem_req && vl_out == '0));

endmodule

// File: tb/ffvec_seq_tb_top.sv
module ffvec_seq_tb_top;

  localparam int MAXVL = 64;
  localparam int IDXW  = $clog2(MAXVL);
  localparam int VLW   = $clog2(MAXVL + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [1:0]      mode_kind = 2'b00;
  logic            opt_snz = 1'b0, opt_inv = 1'b0, opt_rev = 1'b0;
  logic            opt_wide = 1'b0, opt_zero = 1'b0, dst_scalar = 1'b0;
  logic [1:0]      bit_sel = 2'd0;
  logic [VLW-1:0]  vl_in = '0;
  logic            elem_req, wr_en, done, illegal;
  logic [IDXW-1:0] elem_idx, wr_idx;
  logic [VLW-1:0]  vl_out;
  logic [3:0]      elem_res;
  logic            elem_pred;

  logic [3:0] res_m [MAXVL];
  logic       pred_m [MAXVL];

  assign elem_res  = res_m[elem_idx];
  assign elem_pred = pred_m[elem_idx];

  always #4 clk = ~clk;

  ffvec_seq #(.MAXVL(MAXVL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_kind(mode_kind),
    .opt_snz(opt_snz), .opt_inv(opt_inv), .opt_rev(opt_rev),
    .opt_wide(opt_wide), .opt_zero(opt_zero), .bit_sel(bit_sel),
    .dst_scalar(dst_scalar), .vl_in(vl_in), .elem_req(elem_req),
    .elem_idx(elem_idx), .elem_res(elem_res), .elem_pred(elem_pred),
    .wr_en(wr_en), .wr_idx(wr_idx), .vl_out(vl_out), .done(done),
    .illegal(illegal)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string cur_tag = "R12";
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // monitor: pops one expected destination per write strobe
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected write idx", int'(wr_idx), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(wr_idx) == e, cur_tag, "write idx", int'(wr_idx), e);
      end
    end
  end

  task automatic set_data(input logic [3:0] rv, input logic pv);
    for (int i = 0; i < MAXVL; i++) begin
      res_m[i]  = rv;
      pred_m[i] = pv;
    end
  endtask

  // driver: builds expected writes and VL from the requirements, then runs
  task automatic run_case(input string tag, input logic [1:0] kind,
                          input logic snz, input logic inv, input logic rev,
                          input logic wide, input logic zro, input logic [1:0] bs,
                          input logic scal, input int vl);
    bit ill, ff, mr, vli, zero, act, t, fl;
    int exp_vl, i;
    cur_tag = tag;
    ill  = !kind[0] && (snz || inv);
    ff   = kind[0];
    mr   = (kind != 2'b00);
    vli  = (kind == 2'b11);
    zero = (ff && !wide) ? 1'b1 : zro;
    exp_vl = vl;
    if (!ill) begin
      for (int k = 0; k < vl; k++) begin
        i = rev ? (vl - 1 - k) : k;
        act = pred_m[i] || zero;
        if (!act) continue;
        t  = pred_m[i] ? (res_m[i][bs] ^ inv) : snz;
        fl = ff && t;
        if (!fl || vli) exp_q.push_back(scal ? 0 : i);
        if (fl) begin
          exp_vl = k + int'(vli);
          break;
        end
        if (!mr && scal) break;
      end
    end
    @(negedge clk);
    mode_kind = kind; opt_snz = snz; opt_inv = inv; opt_rev = rev;
    opt_wide = wide; opt_zero = zro; bit_sel = bs; dst_scalar = scal;
    vl_in = VLW'(vl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(int'(vl_out) == exp_vl, tag, "vl_out", int'(vl_out), exp_vl);
    chk(illegal == ill, tag, "illegal", int'(illegal), int'(ill));
    chk(exp_q.size() == 0, tag, "missing writes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    finish_run();
  end

  initial begin
    set_data(4'h0, 1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(done == 0, "R12", "done", int'(done), 0);
    chk(illegal == 0, "R12", "illegal", int'(illegal), 0);
    chk(wr_en == 0, "R12", "wr_en", int'(wr_en), 0);
    chk(elem_req == 0, "R12", "elem_req", int'(elem_req), 0);
    chk(vl_out == 0, "R12", "vl_out", int'(vl_out), 0);

    // R5 / R1 plain vector, all written
    for (int i = 0; i < MAXVL; i++) res_m[i] = 4'(i * 7 + 3);
    run_case("R5", 2'b00, 0, 0, 0, 0, 0, 2'd1, 0, 8);

    // R3 fail-first forward, tested bit 2, fail at element 5
    set_data(4'h0, 1'b1); res_m[5] = 4'b0100; res_m[7] = 4'b0100;
    run_case("R3", 2'b01, 0, 0, 0, 0, 0, 2'd2, 0, 10);
    // R4 inclusive variant
    run_case("R4", 2'b11, 0, 0, 0, 0, 0, 2'd2, 0, 10);
    // R1 reduce kind ignores the condition
    run_case("R1", 2'b10, 0, 0, 0, 0, 0, 2'd2, 0, 10);

    // R9 inversion: bit 0 set everywhere except element 3
    set_data(4'b0001, 1'b1); res_m[3] = 4'b1110;
    run_case("R9", 2'b01, 0, 1, 0, 0, 0, 2'd0, 0, 12);

    // R10 reverse, fail at element 6 on bit 1
    set_data(4'h0, 1'b1); res_m[6] = 4'b0010; res_m[2] = 4'b0010;
    run_case("R10", 2'b01, 0, 0, 1, 0, 0, 2'd1, 0, 10);
    run_case("R10", 2'b11, 0, 0, 1, 0, 0, 2'd1, 0, 10);

    // R8 SNZ: masked element 4 stops the loop
    set_data(4'h0, 1'b1); pred_m[4] = 1'b0;
    run_case("R8", 2'b01, 1, 0, 0, 0, 0, 2'd3, 0, 9);
    // R7 narrow fail-first zeroes masked element without SNZ
    run_case("R7", 2'b01, 0, 0, 0, 0, 0, 2'd3, 0, 9);
    // R7 wide without zeroing skips masked element 2
    set_data(4'h0, 1'b1); pred_m[2] = 1'b0; res_m[6] = 4'b1000;
    run_case("R7", 2'b01, 0, 0, 0, 1, 0, 2'd3, 0, 9);
    run_case("R7", 2'b01, 0, 0, 0, 1, 1, 2'd3, 0, 9);

    // R6 scalar destination
    set_data(4'h0, 1'b1); pred_m[0] = 1'b0;
    run_case("R6", 2'b10, 0, 0, 0, 0, 0, 2'd0, 1, 6);
    run_case("R6", 2'b00, 0, 0, 0, 0, 0, 2'd0, 1, 6);
    res_m[4] = 4'b0001;
    run_case("R6", 2'b01, 0, 0, 0, 1, 0, 2'd0, 1, 6);

    // R2 reserved encodings
    run_case("R2", 2'b10, 0, 1, 0, 0, 0, 2'd0, 0, 5);
    run_case("R2", 2'b00, 1, 0, 0, 0, 0, 2'd0, 0, 7);

    // R11 empty vector
    run_case("R11", 2'b01, 0, 0, 0, 0, 0, 2'd0, 0, 0);

    // R5 largest VL, both directions, no failure
    set_data(4'b0111, 1'b1);
    run_case("R5", 2'b01, 0, 0, 0, 0, 0, 2'd3, 0, MAXVL);
    run_case("R5", 2'b11, 0, 0, 1, 0, 0, 2'd3, 0, MAXVL);
    // R10 fail at top element in reverse at full length
    res_m[MAXVL-1] = 4'b1000;
    run_case("R10", 2'b01, 0, 0, 1, 0, 0, 2'd3, 0, MAXVL);

    // R12 result holds while idle
    repeat (4) @(negedge clk);
    chk(done == 1, "R12", "done held", int'(done), 1);
    chk(vl_out == 0, "R12", "vl held", int'(vl_out), 0);

    finish_run();
  end

endmodule